// File: doc/BRIEF.md
# Slew-Limited Reference Ramp Generator

This block produces the digital reference code that sets the output of a switching regulator. It holds a programmed target code and moves the live reference toward it one fixed step at a time. The slew rate is set by the time between steps, not by the step size, so the rate can be changed without changing the resolution of the ramp. The same step size and rate apply upward and downward. When the block is enabled it starts at zero and climbs to the target. When it is disabled it drops back to zero at once.

Target codes use a 5 mV unit. A coarse mode moves two codes (10 mV) per step and a fine mode moves one code (5 mV) per step. Codes below 300 mV are reserved. Writing one has no effect, and the last valid target stays in force. While the regulator reports an active current limit, upward steps stop and downward steps carry on. A new target written during a ramp turns the ramp from its present value, with no jump. The output code goes to a DAC outside this block, and a done flag shows when the reference has settled on the target.

Top module: `ref_ramp_gen`

## Requirements
- R1: After reset the held target is code 100 (500 mV), so enabling with no valid target written ramps the output to 100.
- R2: A target code below 60 (300 mV) is ignored and the previously held target stays; a code of 60 or more is taken on the next clock.
- R3: Each step changes the output by 2 codes when `fine_mode` is 0 and by 1 code when `fine_mode` is 1.
- R4: Steps are spaced BASE_DIV >> (slew_sel + fine_mode) clock cycles apart; slew_sel 0 is the slowest rate and each increment halves the interval, so the slew rate in mV per µs does not depend on the step mode.
- R5: A target below the present output makes the output step downward with the same step size and spacing as an upward ramp.
- R6: On enable the output starts at 0, and the first step lands exactly one full step interval after the first clock edge with `en` high.
- R7: While `ilim_active` is high, upward steps are withheld and downward steps continue; upward stepping resumes after it falls.
- R8: The last step of a ramp is clamped so the output equals the target exactly, with no overshoot, even for an odd distance in coarse mode; `ramp_done` is high whenever the block is enabled and the output equals the held target.
- R9: A target change during a ramp redirects the ramp from the present output; the output never moves by more than one step per step time.
- R10: With `en` low, the output is 0 and `ramp_done` is 0 from the next clock on.
- R11: Reset is synchronous and active low: the output does not change before the clock edge, and after it the output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Run the ramp; low forces the output to zero |
| tgt_code | input | 9 | Requested target code, 5 mV per LSB |
| slew_sel | input | 2 | Rate select, 0 slowest, 3 fastest |
| fine_mode | input | 1 | 0: 2 codes per step, 1: 1 code per step |
| ilim_active | input | 1 | Current limit is active; hold upward steps |
| ref_code | output | 9 | Present reference code for the DAC |
| ramp_done | output | 1 | Enabled and output equal to the held target |

## Verification
The hardest cases to reach are the ones where the target moves while a ramp is running. A retarget that reverses direction, or that leaves an odd distance in coarse mode, tests the clamp and the no-jump rule at a step the bench cannot predict from a single write. The held target also lags the input pin by one clock. The stimulus writes new targets, valid and reserved, at random points of a ramp, and raises the current limit during both rising and falling ramps. A monitor predicts every output change from the target the design has actually taken and from the spacing the rate select calls for.

// File: rtl/ref_ramp_pkg.sv
// Package: shared constants and types for the reference ramp generator.
// Assumes a 5 mV code unit; all sizes below are defaults that modules may override.
package ref_ramp_pkg;
    parameter int REF_W    = 9;    // width of a reference code
    parameter int MIN_CODE = 60;   // lowest accepted target (300 mV)
    parameter int RST_CODE = 100;  // target after reset (500 mV)
    parameter int BASE_DIV = 3280; // clocks per slowest coarse step (16.4 us at 200 MHz)

    typedef enum logic {
        STEP_COARSE = 1'b0,
        STEP_FINE   = 1'b1
    } step_mode_e;
endpackage

// File: rtl/ramp_tick_gen.sv
// Module: ramp_tick_gen
// Emits a one-cycle step strobe every BASE_DIV >> (slew_sel + fine) clocks
// while enabled. Assumes BASE_DIV >> 4 is at least 2, so strobes never touch.
module ramp_tick_gen #(
    parameter int BASE_DIV = ref_ramp_pkg::BASE_DIV
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic [1:0] slew_sel,
    input  logic       fine,
    output logic       tick
);
    localparam int CNT_W = $clog2(BASE_DIV + 1);
    localparam logic [CNT_W-1:0] BASE_W = CNT_W'(BASE_DIV);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] lim;
    logic [2:0]       shift;

    // Interval length picked by rate select and step mode.
    always_comb begin
        shift = {1'b0, slew_sel} + {2'b00, fine};
        lim   = BASE_W >> shift;
    end

    assign tick = en && (cnt_q >= lim - CNT_W'(1));

    // Interval counter, cleared while disabled so a ramp starts on a full interval.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // R4
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/ramp_target_hold.sv
// Module: ramp_target_hold
// Keeps the last valid target. Codes below MIN_CODE are reserved and dropped.
// Assumes the requested code is stable around the clock edge.
module ramp_target_hold #(
    parameter int REF_W    = ref_ramp_pkg::REF_W,
    parameter int MIN_CODE = ref_ramp_pkg::MIN_CODE,
    parameter int RST_CODE = ref_ramp_pkg::RST_CODE
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REF_W-1:0] req_code,
    output logic [REF_W-1:0] tgt_q
);
    localparam logic [REF_W-1:0] MIN_W = REF_W'(MIN_CODE);
    localparam logic [REF_W-1:0] RST_W = REF_W'(RST_CODE);

    // Take the request only when it lies in the allowed range.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_q <= RST_W;
        end else if (req_code >= MIN_W) begin
            tgt_q <= req_code;
        end
    end

    // R2
    tgt_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_q >= MIN_W);
endmodule

// File: rtl/ramp_stepper.sv
// Module: ramp_stepper
// Moves the reference one step toward the target on each strobe, clamps the
// last step onto the target, and holds upward motion under current limit.
// Assumes the strobe is never high on two cycles in a row.
module ramp_stepper #(
    parameter int REF_W = ref_ramp_pkg::REF_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en,
    input  logic                     tick,
    input  ref_ramp_pkg::step_mode_e mode,
    input  logic                     ilim,
    input  logic [REF_W-1:0]         tgt,
    output logic [REF_W-1:0]         ref_q,
    output logic                     done
);
    localparam int EXT_W = REF_W + 1;

    logic             run_q;
    logic [EXT_W-1:0] step;
    logic [EXT_W-1:0] ref_x;
    logic [EXT_W-1:0] tgt_x;
    logic [REF_W-1:0] ref_nxt;

    // Step size and distances in one extra bit so nothing wraps.
    always_comb begin
        step  = (mode == ref_ramp_pkg::STEP_FINE) ? EXT_W'(1) : EXT_W'(2);
        ref_x = {1'b0, ref_q};
        tgt_x = {1'b0, tgt};
    end

    // Next reference: one step toward the target, clamped on the last one.
    always_comb begin
        ref_nxt = ref_q;
        if (ref_q < tgt && !ilim) begin
            ref_nxt = (tgt_x - ref_x <= step) ? tgt : REF_W'(ref_x + step);
        end else if (ref_q > tgt) begin
            ref_nxt = (ref_x - tgt_x <= step) ? tgt : REF_W'(ref_x - step);
        end
    end

    // Reference register and run flag; disable or reset returns to zero.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            ref_q <= '0;
            run_q <= 1'b0;
        end else begin
            run_q <= 1'b1;
            if (tick) begin
                ref_q <= ref_nxt;
            end
        end
    end

    assign done = run_q && (ref_q == tgt);

    // R7
    ilim_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && ilim && ref_q < tgt) |=> (ref_q <= $past(ref_q)));

    // R9
    step_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> (({1'b0, ref_q} <= {1'b0, $past(ref_q)} + EXT_W'(2)) &&
                ({1'b0, ref_q} + EXT_W'(2) >= {1'b0, $past(ref_q)})));

    // R10
    off_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (ref_q == '0 && !done));
endmodule

// File: rtl/ref_ramp_gen.sv
// Module: ref_ramp_gen (top)
// Slew-limited reference ramp: target filter, step-interval divider and stepper.
// Assumes all inputs are synchronous to clk.
module ref_ramp_gen #(
    parameter int REF_W    = ref_ramp_pkg::REF_W,
    parameter int MIN_CODE = ref_ramp_pkg::MIN_CODE,
    parameter int RST_CODE = ref_ramp_pkg::RST_CODE,
    parameter int BASE_DIV = ref_ramp_pkg::BASE_DIV
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [REF_W-1:0] tgt_code,
    input  logic [1:0]       slew_sel,
    input  logic             fine_mode,
    input  logic             ilim_active,
    output logic [REF_W-1:0] ref_code,
    output logic             ramp_done
);
    logic [REF_W-1:0]         tgt_q;
    logic                     tick;
    ref_ramp_pkg::step_mode_e mode;

    assign mode = ref_ramp_pkg::step_mode_e'(fine_mode);

    ramp_target_hold #(
        .REF_W(REF_W), .MIN_CODE(MIN_CODE), .RST_CODE(RST_CODE)
    ) u_hold (
        .clk(clk), .rst_n(rst_n), .req_code(tgt_code), .tgt_q(tgt_q)
    );

    ramp_tick_gen #(.BASE_DIV(BASE_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .en(en), .slew_sel(slew_sel),
        .fine(fine_mode), .tick(tick)
    );

    ramp_stepper #(.REF_W(REF_W)) u_step (
        .clk(clk), .rst_n(rst_n), .en(en), .tick(tick), .mode(mode),
        .ilim(ilim_active), .tgt(tgt_q), .ref_q(ref_code), .done(ramp_done)
    );
endmodule

// File: tb/ref_ramp_gen_bench.sv
`timescale 1ns/1ps
module ref_ramp_gen_bench;
    localparam int DIV = 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [8:0] tgt_code = 9'd0;
    logic [1:0] slew_sel = 2'd0;
    logic       fine_mode = 1'b0;
    logic       ilim_active = 1'b0;
    logic [8:0] ref_code;
    logic       ramp_done;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int epoch = 0;
    int mtgt = 100;
    bit finished = 0;

    ref_ramp_gen #(.BASE_DIV(DIV)) u_ref_ramp_gen (
        .clk(clk), .rst_n(rst_n), .en(en), .tgt_code(tgt_code),
        .slew_sel(slew_sel), .fine_mode(fine_mode), .ilim_active(ilim_active),
        .ref_code(ref_code), .ramp_done(ramp_done)
    );

    always #2.5 clk = ~clk;

    function automatic int lim_of(int s, int f);
        return DIV >> (s + f);
    endfunction

    function automatic int next_ref(int cur, int tg, int f, bit lim);
        int st = f ? 1 : 2;
        if (cur < tg && !lim) return (tg - cur <= st) ? tg : cur + st;
        if (cur > tg)         return (cur - tg <= st) ? tg : cur - st;
        return cur;
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic set_tgt(int v);
        @(negedge clk);
        tgt_code = 9'(v);
        if (v >= 60) mtgt = v;
        epoch++;
    endtask

    task automatic set_cfg(int s, int f);
        @(negedge clk);
        slew_sel = 2'(s);
        fine_mode = f[0];
        epoch++;
    endtask

    task automatic set_ilim(bit v);
        @(negedge clk);
        ilim_active = v;
        epoch++;
    endtask

    task automatic wait_done(int limit);
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if (ramp_done) return;
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000 && !finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Monitor: predicts every output change (R3 R4 R5 R7 R8 R9).
    int prev_ref = 0;
    int lat_prev = 100;
    int last_cyc = 0;
    int last_ep = 0;
    bit have_last = 0;
    initial begin
        forever begin
            int used;
            @(posedge clk); #1;
            used = lat_prev;
            lat_prev = mtgt;
            if (!rst_n || !en) begin
                have_last = 0;
            end else if (int'(ref_code) != prev_ref) begin
                chk(int'(ref_code) == next_ref(prev_ref, used, fine_mode, ilim_active),
                    "R3/R5/R7/R8/R9 step value", ref_code,
                    next_ref(prev_ref, used, fine_mode, ilim_active));
                if (have_last && last_ep == epoch)
                    chk(cyc - last_cyc == lim_of(slew_sel, fine_mode),
                        "R4 step spacing", cyc - last_cyc, lim_of(slew_sel, fine_mode));
                last_cyc = cyc;
                last_ep = epoch;
                have_last = 1;
            end
            prev_ref = ref_code;
        end
    end

    initial begin
        int n;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(ref_code == 0, "R11 reset output", ref_code, 0);
        chk(ramp_done == 0, "R11 reset done", ramp_done, 0);
        rst_n = 1'b1;
        epoch++;

        // R6 R1 R2: enable with a reserved target, first step timing.
        @(negedge clk);
        en = 1'b1;
        epoch++;
        n = 0;
        while (ref_code == 0 && n < 100) begin
            @(posedge clk); #1;
            n++;
        end
        chk(n == lim_of(0, 0), "R6 first step delay", n, lim_of(0, 0));
        chk(ref_code == 2, "R6 first step from zero", ref_code, 2);
        chk(ramp_done == 0, "R8 not done mid ramp", ramp_done, 0);
        wait_done(5000);
        chk(ref_code == 100, "R1 reset target", ref_code, 100);

        // R8: odd distance in coarse mode lands exactly.
        set_tgt(107);
        wait_done(5000);
        chk(ref_code == 107, "R8 clamp odd coarse", ref_code, 107);
        chk(ramp_done == 1, "R8 done flag", ramp_done, 1);

        // R5: fine downward ramp at the fastest rate.
        set_cfg(3, 1);
        set_tgt(60);
        wait_done(5000);
        chk(ref_code == 60, "R5 down to minimum", ref_code, 60);

        // R2: reserved code leaves output and done untouched.
        set_tgt(59);
        repeat (40) @(negedge clk);
        chk(ref_code == 60, "R2 reserved ignored", ref_code, 60);
        chk(ramp_done == 1, "R2 done kept", ramp_done, 1);

        // R7: current limit holds an upward ramp.
        set_cfg(2, 0);
        set_ilim(1'b1);
        set_tgt(200);
        repeat (100) @(negedge clk);
        chk(ref_code == 60, "R7 upward held", ref_code, 60);
        set_ilim(1'b0);
        wait_done(5000);
        chk(ref_code == 200, "R7 resumes", ref_code, 200);

        // R7: downward ramp continues under current limit.
        set_ilim(1'b1);
        set_tgt(151);
        wait_done(5000);
        chk(ref_code == 151, "R7 down under limit", ref_code, 151);
        set_ilim(1'b0);

        // R9: reversal mid ramp.
        set_cfg(1, 0);
        set_tgt(400);
        repeat (300) @(negedge clk);
        chk(ref_code > 151 && ref_code < 400, "R9 mid ramp", ref_code, 275);
        set_tgt(170);
        wait_done(8000);
        chk(ref_code == 170, "R9 redirected", ref_code, 170);

        // R10: disable clears output and done on the next clock.
        @(negedge clk);
        en = 1'b0;
        epoch++;
        @(negedge clk);
        chk(ref_code == 0, "R10 output zero", ref_code, 0);
        chk(ramp_done == 0, "R10 done low", ramp_done, 0);
        repeat (50) @(negedge clk);
        chk(ref_code == 0, "R10 stays zero", ref_code, 0);
        @(negedge clk);
        en = 1'b1;
        epoch++;
        wait_done(8000);
        chk(ref_code == 170, "R6 ramp after re-enable", ref_code, 170);

        // R11: synchronous reset, then R1 held target restored.
        set_tgt(0);
        @(negedge clk);
        rst_n = 1'b0;
        mtgt = 100;
        epoch++;
        #0.5;
        chk(ref_code == 170, "R11 no async clear", ref_code, 170);
        @(posedge clk); #1;
        chk(ref_code == 0, "R11 cleared at edge", ref_code, 0);
        @(negedge clk);
        rst_n = 1'b1;
        epoch++;
        wait_done(8000);
        chk(ref_code == 100, "R1 target after reset", ref_code, 100);

        // Random phase: targets, rates, modes, retargets, limit pulses.
        for (int it = 0; it < 30; it++) begin
            int t = $urandom_range(511, 0);
            set_cfg($urandom_range(3, 0), $urandom_range(1, 0));
            set_tgt(t);
            if ($urandom_range(3, 0) == 0) begin
                repeat ($urandom_range(400, 20)) @(negedge clk);
                set_tgt($urandom_range(511, 0));
            end
            if ($urandom_range(3, 0) == 0) begin
                set_ilim(1'b1);
                repeat ($urandom_range(200, 10)) @(negedge clk);
                set_ilim(1'b0);
            end
            wait_done(20000);
            chk(ref_code == 9'(mtgt), "R8 random settle", ref_code, mtgt);
            chk(ramp_done == 1, "R8 random done", ramp_done, 1);
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule